// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block connects an 8-bit processor core to off-chip memory through a multiplexed byte-wide bus. The core hands over one access at a time on a valid/ready request channel. Each request carries a 16-bit address, a write flag, write data and a flag that picks data space or program space. The controller then runs a fixed sequence of bus phases. First comes an address phase, with the address strobe low, the high address byte on its own port and the low address byte on the shared port. Next comes a single turnaround cycle. Last comes a data phase, with the data strobe low, in which read data is captured or write data is presented. The response comes back as a one-cycle pulse carrying the read byte.

Extended timing adds one cycle to the address phase and one cycle to the data phase. A 2-bit automatic wait count adds 0 to 3 more data-phase cycles. An external active-low WAIT input passes through a two-flop synchroniser. The data phase then stays open for as long as WAIT is seen low in the data phase's final counted cycle. The timing mode and the wait count are taken from their configuration pins at the cycle a request is accepted.

Back-pressure applies only to requests: `req_ready` is high in idle and in the final data cycle of an access. A request held valid in that final cycle is accepted there, so its address phase follows the data phase without a gap. Responses have no ready signal, so the core must take `rsp_valid` when it arrives.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and right after it, all six strobes (`as_n`, `ds_n`, `rd_n`, `wr_n`, `dm_n`, `pm_n`) are high, `bus_ad_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The address phase has `as_n` low for 1 cycle in normal timing and 2 cycles in extended timing. Throughout it, `bus_addr_hi` holds address bits 15:8, `bus_ad_o` holds bits 7:0 and `bus_ad_oe` is 1.
- R3: Exactly one cycle with both `as_n` and `ds_n` high lies between the address phase and the data phase. In a read, `bus_ad_oe` is 0 from that cycle to the end of the data phase.
- R4: The data phase has `ds_n` low for 1 cycle (normal) or 2 cycles (extended), plus the automatic wait count (0 to 3). Timing mode and count are sampled at request acceptance; changing the configuration pins later has no effect on the running access.
- R5: `rsp_valid` pulses for exactly one cycle, the first cycle after the last `ds_n` low cycle. For a read, `rsp_rdata` equals the value on `bus_ad_i` in that last `ds_n` low cycle.
- R6: In a write, `bus_ad_o` equals the write data and `bus_ad_oe` is 1 from the turnaround cycle to the end of the data phase, with `wr_n` low and `rd_n` high while `ds_n` is low. In a read, `rd_n` is low and `wr_n` high while `ds_n` is low.
- R7: During an access, a data-space request (`req_dspace`=1) holds `dm_n` low and `pm_n` high, and a program-space request does the opposite. In idle both are high.
- R8: `wait_n` passes through two flops. If it is low at the final counted data cycle, `ds_n` stays low, and the access ends two cycles after the cycle in which `wait_n` returns high.
- R9: WAIT seen low only during earlier auto-wait cycles of the data phase has no effect on the data-phase length.
- R10: `req_ready` is low during the address phase. An accepted request starts its address phase in the next cycle. A request held valid through an access starts its address phase in the cycle right after the last `ds_n` low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext | input | 1 | Extended timing select, sampled at acceptance |
| cfg_auto | input | 2 | Automatic wait count, sampled at acceptance |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dspace | input | 1 | 1 = data space, 0 = program space |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Captured read byte |
| bus_addr_hi | output | 8 | High address byte port |
| bus_ad_o | output | 8 | Shared port output value |
| bus_ad_i | input | 8 | Shared port input value |
| bus_ad_oe | output | 1 | Shared port drive enable |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rd_n | output | 1 | Memory read, active low |
| wr_n | output | 1 | Memory write, active low |
| dm_n | output | 1 | Data-memory select, active low |
| pm_n | output | 1 | Program-memory select, active low |
| wait_n | input | 1 | External wait request, active low, asynchronous |

## Verification
A vector table covers reads and writes in both spaces, both timing modes and several automatic wait counts. Those vectors separate the address-phase length from the data-phase length, and the configuration pins are flipped after acceptance to show that the sampled values alone decide the length. Two WAIT patterns then separate the synchroniser from the counter. A release timed against the count of strobe cycles shows the two-cycle synchroniser delay. A short pulse in the turnaround cycle is ignored when it falls on an early auto-wait cycle, and extends the access when it lands on the final counted cycle. A directed back-to-back pair shows the next address phase following the data strobe with no idle cycle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_GAP  = 2'd2,
    PH_DATA = 2'd3
  } phase_e;
endpackage

// File: rtl/xbus_wait_sync.sv
module xbus_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_n_i,
  output logic hold_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= wait_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= {q[STAGES-2:0], wait_n_i};
      end
    end
  endgenerate

  assign hold_o = ~q[STAGES-1];
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int AUTO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              ext,
  input  logic [AUTO_W-1:0] auto_n,
  input  logic              hold,
  output phase_e            phase,
  output logic              last_slot,
  output logic              finish,
  output logic              fire,
  output logic              req_ready,
  output logic              rsp_pulse
);
  localparam int MAX_DATA = (1 << AUTO_W);
  localparam int CNT_W    = $clog2(MAX_DATA + 1);

  phase_e           phase_q;
  logic             acnt_q;
  logic [CNT_W-1:0] dload_q;
  logic [CNT_W-1:0] dcnt_q;
  logic             rsp_q;

  always_comb begin
    last_slot = (phase_q == PH_DATA) && (dcnt_q == '0);
    finish    = last_slot && !hold;
    req_ready = (phase_q == PH_IDLE) || finish;
    fire      = req_valid && req_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      acnt_q  <= 1'b0;
      dload_q <= '0;
      dcnt_q  <= '0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= finish;
      if (fire) begin
        acnt_q  <= ext;
        dload_q <= CNT_W'(ext) + CNT_W'(auto_n);
      end
      unique case (phase_q)
        PH_IDLE: if (fire) phase_q <= PH_ADDR;
        PH_ADDR: begin
          if (acnt_q) acnt_q <= 1'b0;
          else        phase_q <= PH_GAP;
        end
        PH_GAP: begin
          phase_q <= PH_DATA;
          dcnt_q  <= dload_q;
        end
        PH_DATA: begin
          if (dcnt_q != '0) dcnt_q <= dcnt_q - CNT_W'(1);
          else if (!hold)   phase_q <= fire ? PH_ADDR : PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign rsp_pulse = rsp_q;

  // R5: a completion pulse never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_q |=> !rsp_q);
endmodule

// File: rtl/xbus_pins.sv
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          finish,
  input  phase_e        phase,
  input  logic          req_write,
  input  logic          req_dspace,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_ad_i,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-DW-1:0] bus_addr_hi,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe,
  output logic          as_n,
  output logic          ds_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          dm_n,
  output logic          pm_n
);
  localparam int HI_W = AW - DW;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          wr_q;
  logic          dsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      dsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (fire) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        dsp_q   <= req_dspace;
      end
      if (finish && !wr_q) rdata_q <= bus_ad_i;
    end
  end

  logic in_addr, in_xfer, busy;

  always_comb begin
    in_addr     = (phase == PH_ADDR);
    in_xfer     = (phase == PH_GAP) || (phase == PH_DATA);
    busy        = (phase != PH_IDLE);
    as_n        = !in_addr;
    ds_n        = !(phase == PH_DATA);
    bus_ad_oe   = in_addr || (wr_q && in_xfer);
    bus_ad_o    = in_addr ? addr_q[DW-1:0] : wdata_q;
    rd_n        = !(in_xfer && !wr_q);
    wr_n        = !(in_xfer && wr_q);
    dm_n        = !(busy && dsp_q);
    pm_n        = !(busy && !dsp_q);
    bus_addr_hi = addr_q[AW-1 -: HI_W];
  end

  assign rsp_rdata = rdata_q;

  // R3: a read never drives the shared port while the data strobe is low
  a_r3_read_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && !rd_n) |-> !bus_ad_oe);

  // R6: write data holds steady across the data strobe low phase
  a_r6_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && !wr_n && $past(!ds_n)) |-> $stable(bus_ad_o));

  // R2: address lines do not move inside the address phase
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && $past(!as_n)) |-> ($stable(bus_addr_hi) && $stable(bus_ad_o)));
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int AUTO_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ext,
  input  logic [AUTO_W-1:0] cfg_auto,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_dspace,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-DW-1:0]  bus_addr_hi,
  output logic [DW-1:0]     bus_ad_o,
  input  logic [DW-1:0]     bus_ad_i,
  output logic              bus_ad_oe,
  output logic              as_n,
  output logic              ds_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic              dm_n,
  output logic              pm_n,
  input  logic              wait_n
);
  phase_e phase;
  logic   hold, last_slot, finish, fire;

  xbus_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_n_i (wait_n),
    .hold_o   (hold)
  );

  xbus_seq #(.AUTO_W(AUTO_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ext       (cfg_ext),
    .auto_n    (cfg_auto),
    .hold      (hold),
    .phase     (phase),
    .last_slot (last_slot),
    .finish    (finish),
    .fire      (fire),
    .req_ready (req_ready),
    .rsp_pulse (rsp_valid)
  );

  xbus_pins #(.AW(AW), .DW(DW)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .finish      (finish),
    .phase       (phase),
    .req_write   (req_write),
    .req_dspace  (req_dspace),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .bus_ad_i    (bus_ad_i),
    .rsp_rdata   (rsp_rdata),
    .bus_addr_hi (bus_addr_hi),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe   (bus_ad_oe),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .dm_n        (dm_n),
    .pm_n        (pm_n)
  );

  // R10: an accepted request opens its address phase on the next cycle
  a_r10_accept_starts_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !as_n);

  // R10: no request is taken while the address strobe is low
  a_r10_busy_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |-> !req_ready);

  // R5: a response arrives exactly as the data strobe goes back high
  a_r5_rsp_follows_ds: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (ds_n && $past(!ds_n)));

  // R8: synchronised WAIT at the final counted slot keeps the strobe low
  a_r8_wait_extends: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_n && last_slot && hold) |=> !ds_n);
endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ext = 1'b0;
  logic [1:0] cfg_auto = 2'd0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic       req_dspace = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic [7:0] bus_addr_hi;
  logic [7:0] bus_ad_o;
  logic [7:0] bus_ad_i = '0;
  logic       bus_ad_oe, as_n, ds_n, rd_n, wr_n, dm_n, pm_n;
  logic       wait_n = 1'b1;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .cfg_auto(cfg_auto),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dspace(req_dspace), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bus_addr_hi(bus_addr_hi),
    .bus_ad_o(bus_ad_o), .bus_ad_i(bus_ad_i), .bus_ad_oe(bus_ad_oe),
    .as_n(as_n), .ds_n(ds_n), .rd_n(rd_n), .wr_n(wr_n), .dm_n(dm_n),
    .pm_n(pm_n), .wait_n(wait_n)
  );

  // wmode: 0 none, 1 WAIT low then released after wk strobe cycles, 2 pulse in turnaround
  typedef struct packed {
    logic        wr;
    logic        dsp;
    logic        ext;
    logic [1:0]  aw;
    logic [1:0]  wmode;
    logic [2:0]  wk;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [7:0]  rd;
    logic [1:0]  eas;
    logic [3:0]  eds;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 3'd0, 16'h12A5, 8'h00, 8'h3C, 2'd1, 4'd1},
    '{1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 3'd0, 16'hFF00, 8'h5A, 8'h00, 2'd1, 4'd1},
    '{1'b0, 1'b0, 1'b1, 2'd0, 2'd0, 3'd0, 16'h0001, 8'h00, 8'hC3, 2'd2, 4'd2},
    '{1'b1, 1'b1, 1'b1, 2'd3, 2'd0, 3'd0, 16'h8000, 8'hA5, 8'h00, 2'd2, 4'd5},
    '{1'b0, 1'b1, 1'b0, 2'd2, 2'd0, 3'd0, 16'h7E81, 8'h00, 8'h99, 2'd1, 4'd3},
    '{1'b0, 1'b1, 1'b0, 2'd0, 2'd1, 3'd4, 16'h4242, 8'h00, 8'h18, 2'd1, 4'd6},
    '{1'b1, 1'b0, 1'b1, 2'd2, 2'd1, 3'd1, 16'h0FF0, 8'h81, 8'h00, 2'd2, 4'd4},
    '{1'b0, 1'b1, 1'b0, 2'd3, 2'd2, 3'd0, 16'hABCD, 8'h00, 8'hE7, 2'd1, 4'd4},
    '{1'b1, 1'b1, 1'b0, 2'd1, 2'd2, 3'd0, 16'h5555, 8'h0F, 8'h00, 2'd1, 4'd3}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int as_c = 0, ds_c = 0, gap_c = 0;
    bit e_addr = 0, e_rw = 0, e_sp = 0, pulsed = 0;
    string dtag;
    @(negedge clk);
    cfg_ext = v.ext; cfg_auto = v.aw;
    req_write = v.wr; req_dspace = v.dsp; req_addr = v.addr; req_wdata = v.wd;
    bus_ad_i = v.rd;
    if (v.wmode == 2'd1) wait_n = 1'b0;
    req_valid = 1'b1;
    for (int i = 0; i < 64 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_ext = ~v.ext; cfg_auto = ~v.aw;   // R4: late config change must not matter
    for (int i = 0; i < 64; i++) begin
      if (rsp_valid) break;
      if (!as_n) begin
        as_c++;
        if (bus_addr_hi !== v.addr[15:8] || bus_ad_o !== v.addr[7:0] || !bus_ad_oe || req_ready)
          e_addr = 1;
      end else if (!ds_n) begin
        ds_c++;
        if (v.wr) begin
          if (bus_ad_o !== v.wd || !bus_ad_oe || wr_n || !rd_n) e_rw = 1;
        end else begin
          if (bus_ad_oe || rd_n || !wr_n) e_rw = 1;
        end
      end else begin
        gap_c++;
        if (v.wr && (bus_ad_o !== v.wd || !bus_ad_oe)) e_rw = 1;
        if (!v.wr && bus_ad_oe) e_rw = 1;
      end
      if (dm_n !== !v.dsp || pm_n !== v.dsp) e_sp = 1;
      if (v.wmode == 2'd1 && !ds_n && ds_c == int'(v.wk)) wait_n = 1'b1;
      if (v.wmode == 2'd2) begin
        if (pulsed && !wait_n) wait_n = 1'b1;
        else if (!pulsed && as_n && ds_n) begin
          wait_n = 1'b0;
          pulsed = 1;
        end
      end
      @(negedge clk);
    end
    wait_n = 1'b1;
    chk(as_c == int'(v.eas), $sformatf("R2 vec%0d addr-phase length", idx), as_c, int'(v.eas));
    chk(!e_addr, $sformatf("R2 R10 vec%0d address content / ready low", idx), e_addr, 0);
    chk(gap_c == 1, $sformatf("R3 vec%0d turnaround cycles", idx), gap_c, 1);
    dtag = (v.wmode == 2'd1) ? "R8" : (v.wmode == 2'd2) ? "R9" : "R4";
    chk(ds_c == int'(v.eds), $sformatf("%s vec%0d data-phase length", dtag, idx), ds_c, int'(v.eds));
    chk(!e_rw, $sformatf("R6 vec%0d port direction / rd-wr strobes", idx), e_rw, 0);
    chk(!e_sp, $sformatf("R7 vec%0d space selects", idx), e_sp, 0);
    if (!v.wr)
      chk(rsp_valid && rsp_rdata == v.rd, $sformatf("R5 vec%0d read byte", idx), rsp_rdata, v.rd);
    chk(dm_n && pm_n && as_n && ds_n && !bus_ad_oe, $sformatf("R7 vec%0d idle selects", idx),
        {dm_n, pm_n, as_n, ds_n, bus_ad_oe}, 5'b11110);
    @(negedge clk);
    chk(!rsp_valid, $sformatf("R5 vec%0d response pulse one cycle", idx), rsp_valid, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(as_n && ds_n && rd_n && wr_n && dm_n && pm_n && !bus_ad_oe && !rsp_valid && req_ready,
        "R1 outputs under reset", {as_n, ds_n, rd_n, wr_n, dm_n, pm_n, bus_ad_oe, rsp_valid, req_ready},
        9'b111111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(as_n && ds_n && dm_n && pm_n && !bus_ad_oe && req_ready, "R1 idle after reset",
        {as_n, ds_n, dm_n, pm_n, bus_ad_oe, req_ready}, 6'b111101);

    for (int k = 0; k < NV; k++) run_vec(VT[k], k);

    // R10: back-to-back, second request held valid through the first access
    @(negedge clk);
    cfg_ext = 1'b0; cfg_auto = 2'd0;
    req_write = 1'b0; req_dspace = 1'b1; req_addr = 16'h2211; bus_ad_i = 8'h6E;
    req_valid = 1'b1;
    for (int i = 0; i < 64 && !req_ready; i++) @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_dspace = 1'b0; req_addr = 16'h9988; req_wdata = 8'h77;
    for (int i = 0; i < 64 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_valid && !as_n, "R10 next address phase right after strobe", as_n, 0);
    chk(bus_addr_hi == 8'h99, "R10 second address on port", bus_addr_hi, 8'h99);
    chk(rsp_rdata == 8'h6E, "R5 first read byte in back-to-back", rsp_rdata, 8'h6E);
    chk(!pm_n && dm_n, "R7 second access program space", {dm_n, pm_n}, 2'b10);
    req_valid = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64 && !rsp_valid; i++) @(negedge clk);
    chk(rsp_valid && wr_n && rd_n && dm_n && pm_n, "R10 second access completes",
        {rsp_valid, wr_n, rd_n, dm_n, pm_n}, 5'b11111);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule